// File: doc/BRIEF.md
# Toggle-Bit Status Responder

This block supplies the read-side status logic of a flash bank while an embedded program or erase runs. A one-cycle pulse taken at the final write strobe of a command sequence starts an operation for the bank named with it. From that point, every read aimed at that bank returns a status byte instead of array data. Bit 6 of the status byte flips on each such read, so a host that reads twice and compares can tell whether the operation is still running. Reads to other banks keep returning array contents and leave the toggle alone.

The program/erase algorithm itself sits outside the block. Its progress arrives as a busy level from an engine timer. An operation ends when that busy level has been seen high and has then dropped. If the command reported that every targeted sector is protected, the block ignores the busy level. It then keeps the status visible for a fixed time window, counted in clock cycles from the clock frequency and the window length in microseconds, and after that falls back to normal reads. Each end of an operation produces a one-cycle done pulse.

Top module: `toggle_status_resp`

## Requirements
- R1: After reset, `rd_valid` and `op_done` are 0, and the block is idle, so reads return array data.
- R2: A read presented with `rd_en` high yields `rd_valid` high and `rd_data` on the following cycle. While no operation is active, `rd_data` equals the `array_data` presented with the read.
- R3: While an operation is active, a read to the operation's bank returns a status byte. In that byte every bit is 0 except bit 6, which holds the toggle value. The toggle inverts after each such read, and only such reads advance it.
- R4: During an operation, a read to any other bank returns that read's `array_data` and does not advance the toggle.
- R5: Status reads are valid from the cycle after `cmd_accept`, before `engine_busy` has ever risen.
- R6: For an unprotected operation, the first cycle in which `engine_busy` is low after having been high ends the operation. `op_done` is then high for exactly one cycle, and later reads to the bank return array data.
- R7: When `all_prot` is high with `cmd_accept`, the operation ignores `engine_busy` and stays active for exactly PROT_CYCLES = CLK_MHZ*PROT_US cycles after the accept edge. It then ends with a one-cycle `op_done`.
- R8: The toggle is 0 at the start of every new operation, so the first status read returns 0x00.
- R9: A `cmd_accept` arriving while an operation is active is ignored. The bank, the mode and the toggle all stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_accept | input | 1 | One-cycle pulse at the final write strobe of a command |
| cmd_bank | input | BANK_W | Bank targeted by the accepted command |
| all_prot | input | 1 | All sectors targeted by the command are protected |
| engine_busy | input | 1 | Busy level from the program/erase engine timer |
| rd_en | input | 1 | Read request |
| rd_bank | input | BANK_W | Bank of the read address |
| array_data | input | DATA_W | Array word for the read address |
| rd_data | output | DATA_W | Returned read data |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| op_done | output | 1 | One-cycle pulse when an operation ends |

## Verification
The bench builds the block with CLK_MHZ=1 and PROT_US=24, so the protected-sector window lasts 24 cycles. With that setting the bench can count the window to the exact cycle, where the default would make the window ten thousand cycles long. A bank width of 2 leaves room for reads to the busy bank and to a different bank within one operation. It also allows a second command during an active operation, to show that the second command is dropped.

// File: rtl/toggle_status_resp.sv
module toggle_status_resp #(
  parameter int DATA_W  = 8,
  parameter int BANK_W  = 2,
  parameter int TOG_BIT = 6,
  parameter int CLK_MHZ = 100,
  parameter int PROT_US = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_accept,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              all_prot,
  input  logic              engine_busy,
  input  logic              rd_en,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              op_done
);
  localparam int PROT_CYCLES = CLK_MHZ * PROT_US;
  localparam int CNT_W = $clog2(PROT_CYCLES + 1);
  localparam logic [DATA_W-1:0] TOG_MASK = DATA_W'(1) << TOG_BIT;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_RUN, S_PROT} st_t;

  st_t              state;
  logic [BANK_W-1:0] op_bank;
  logic             tog;
  logic [CNT_W-1:0] prot_cnt;

  wire active   = (state != S_IDLE);
  wire hit      = rd_en && active && (rd_bank == op_bank);
  wire run_end  = (state == S_RUN) && !engine_busy;
  wire prot_end = (state == S_PROT) && (prot_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_bank  <= '0;
      prot_cnt <= '0;
      op_done  <= 1'b0;
    end else begin
      op_done <= run_end || prot_end;
      case (state)
        S_IDLE: if (cmd_accept) begin
          op_bank  <= cmd_bank;
          prot_cnt <= CNT_W'(PROT_CYCLES - 1);
          state    <= all_prot ? S_PROT : S_ARMED;
        end
        S_ARMED: if (engine_busy) state <= S_RUN;
        S_RUN:   if (!engine_busy) state <= S_IDLE;
        S_PROT:  if (prot_cnt == '0) state <= S_IDLE;
                 else prot_cnt <= prot_cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog      <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= hit ? (tog ? TOG_MASK : '0) : array_data;
      if (state == S_IDLE && cmd_accept) tog <= 1'b0;
      else if (hit) tog <= ~tog;
    end
  end

  // R6 R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);

  // R2
  idle_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && state == S_IDLE) |=> (rd_valid && rd_data == $past(array_data)));

  // R7
  prot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PROT) |-> (prot_cnt < CNT_W'(PROT_CYCLES)));

  // R8
  tog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && cmd_accept) |=> (!tog && state != S_IDLE));

  // R9
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cmd_accept && !rd_en && !run_end && !prot_end) |=> $stable(op_bank) && $stable(tog));
endmodule

// File: tb/toggle_status_resp_tb.sv
module toggle_status_resp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ = 1;
  localparam int PROT_US = 24;
  localparam int PROT_CYCLES = CLK_MHZ * PROT_US;

  logic clk = 0, rst_n = 0;
  logic cmd_accept = 0, all_prot = 0, engine_busy = 0, rd_en = 0;
  logic [1:0] cmd_bank = 0, rd_bank = 0;
  logic [7:0] array_data = 0, rd_data;
  logic rd_valid, op_done;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  toggle_status_resp #(.DATA_W(8), .BANK_W(2), .TOG_BIT(6), .CLK_MHZ(CLK_MHZ), .PROT_US(PROT_US)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_accept(cmd_accept), .cmd_bank(cmd_bank),
    .all_prot(all_prot), .engine_busy(engine_busy), .rd_en(rd_en), .rd_bank(rd_bank),
    .array_data(array_data), .rd_data(rd_data), .rd_valid(rd_valid), .op_done(op_done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with outputs sampled
  task automatic do_read(input logic [1:0] bank, input logic [7:0] arr, input logic [7:0] exp, input string req);
    rd_en = 1; rd_bank = bank; array_data = arr;
    @(negedge clk);
    rd_en = 0;
    check(rd_valid === 1'b1, {req, " rd_valid"}, int'(rd_valid), 1);
    check(rd_data === exp, req, int'(rd_data), int'(exp));
  endtask

  task automatic accept(input logic [1:0] bank, input logic prot);
    cmd_accept = 1; cmd_bank = bank; all_prot = prot;
    @(negedge clk);
    cmd_accept = 0; all_prot = 0;
  endtask

  task automatic t_reset;
    check(rd_valid === 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    check(op_done === 1'b0, "R1 op_done", int'(op_done), 0);
    do_read(2'd1, 8'h5A, 8'h5A, "R1 R2 idle read");
  endtask

  task automatic t_run;
    accept(2'd1, 1'b0);
    do_read(2'd1, 8'hFF, 8'h00, "R5 R8 first status before busy");
    do_read(2'd1, 8'hFF, 8'h40, "R3 second status");
    do_read(2'd2, 8'hA5, 8'hA5, "R4 other bank data");
    do_read(2'd1, 8'hFF, 8'h00, "R4 toggle not advanced by other bank");
    repeat (3) @(negedge clk);
    do_read(2'd1, 8'hFF, 8'h40, "R3 idle cycles keep toggle");
    engine_busy = 1;
    @(negedge clk);
    do_read(2'd1, 8'hFF, 8'h00, "R3 status while busy");
    accept(2'd3, 1'b1);
    do_read(2'd1, 8'hFF, 8'h40, "R9 second command ignored");
    do_read(2'd3, 8'h77, 8'h77, "R9 bank unchanged");
    do_read(2'd1, 8'hFF, 8'h00, "R3 toggle continues");
    check(op_done === 1'b0, "R6 no done while busy", int'(op_done), 0);
    engine_busy = 0;
    @(negedge clk);
    check(op_done === 1'b1, "R6 done pulse", int'(op_done), 1);
    @(negedge clk);
    check(op_done === 1'b0, "R6 done one cycle", int'(op_done), 0);
    do_read(2'd1, 8'h3C, 8'h3C, "R6 array data after done");
  endtask

  task automatic t_prot;
    int n = 0;
    bit seen = 0;
    accept(2'd0, 1'b1);
    do_read(2'd0, 8'hFF, 8'h00, "R8 toggle cleared on new op");
    do_read(2'd0, 8'hFF, 8'h40, "R7 status in protect window");
    engine_busy = 1;
    do_read(2'd0, 8'hFF, 8'h00, "R7 busy ignored");
    engine_busy = 0;
    n = 3;
    while (!seen && n < PROT_CYCLES + 10) begin
      @(negedge clk);
      n++;
      if (op_done === 1'b1) seen = 1;
    end
    check(n == PROT_CYCLES, "R7 window length", n, PROT_CYCLES);
    @(negedge clk);
    check(op_done === 1'b0, "R7 done one cycle", int'(op_done), 0);
    do_read(2'd0, 8'h81, 8'h81, "R7 array data after window");
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_run();
    t_prot();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule